// File: doc/BRIEF.md
# Cache-Aware Grouped Warp Scheduler

This block chooses, every cycle, one warp to issue from a fixed pool of warps. The pool is split into equal groups of consecutive warps. One group holds strict priority. Its eligible warps always win over every other group, so only a small number of groups touch the data cache in any window of time. A round-robin scheduler across all warps would spread accesses over every group.

Priority does not rotate. It moves only in two cases. The first is that every warp of the priority group is waiting on memory or has finished; priority then goes to the lowest-numbered group that can issue. The second is that memory data comes back for some warp; that warp's group then takes priority back. Inside the chosen group, a per-group round-robin pointer picks the warp. The grant is combinational from the current inputs and state. Priority and pointers update on the clock edge that follows.

Top module: `cags_sched`

## Requirements
- R1: While `rst_n` is low at a clock edge, the priority group becomes 0 and every group pointer is cleared. After reset, the first grant in any group goes to the lowest eligible local warp of that group.
- R2: Warp w is eligible only when `warp_ready[w]` is 1, `warp_mem_stall[w]` is 0 and `warp_finished[w]` is 0. A warp that is not eligible is never granted.
- R3: Warp w belongs to group w / GROUP_SIZE and has local index w % GROUP_SIZE. When the priority group has an eligible warp, the grant goes to a warp of that group in the same cycle.
- R4: Within a group, the search starts at the local index one past the last warp granted from that group. It wraps around the group and takes the first eligible warp. Each group has its own pointer, and a pointer moves only when its group is granted.
- R5: When the priority group has no eligible warp but another group has one, the grant goes to the lowest-numbered group with an eligible warp. The priority group stays unchanged unless R6 or R7 applies.
- R6: When every warp of the priority group has its stall or finished flag set and no data return is present, the next cycle's priority group is the lowest-numbered group that has an eligible warp. If no group has an eligible warp, the priority group is held.
- R7: When `dret_valid` is 1, the next cycle's priority group is `dret_warp` / GROUP_SIZE. This holds even when the R6 switch condition is present in the same cycle.
- R8: When no warp is eligible, `grant_valid` is 0 and all group pointers are held. The priority group is held too, except that R7 still applies.
- R9: `grant_valid` and `grant_warp` follow the current inputs in the same cycle. `prio_group` is a registered output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| warp_ready | input | NUM_WARPS | Per-warp ready to issue |
| warp_mem_stall | input | NUM_WARPS | Per-warp waiting on memory |
| warp_finished | input | NUM_WARPS | Per-warp finished |
| dret_valid | input | 1 | Memory data returned this cycle |
| dret_warp | input | log2(NUM_WARPS) | Warp the returned data belongs to |
| grant_valid | output | 1 | A warp is granted this cycle |
| grant_warp | output | log2(NUM_WARPS) | Granted warp |
| prio_group | output | log2(NUM_WARPS/GROUP_SIZE) | Current priority group |

## Verification
The hardest case to reach is a data return that arrives in the same cycle as the switch condition. In that cycle the priority group is completely stalled, a different group is eligible, and the return names a third group. The bench gets there in two steps. A first data return moves priority off group 0. Then, in one cycle, it raises stall on all four warps of the new priority group, keeps a lower-numbered group ready, and presents a return for a higher-numbered group. The bench also checks that a pointer left in mid-rotation survives several idle cycles unchanged.

// File: rtl/cags_pkg.sv
// Shared helpers for the grouped warp scheduler.
// Assumes group sizes are small positive integers.
package cags_pkg;

    // Local index that follows idx inside a group of size entries, wrapping.
    function automatic int unsigned wrap_next(input int unsigned idx, input int unsigned size);
        return (idx + 1) % size;
    endfunction

endpackage

// File: rtl/cags_group_arbiter.sv
// Round-robin picker for one warp group.
// Holds a pointer to the local warp after the last one granted from this group.
// Assumes GROUP_SIZE is a power of two and at least 2.
module cags_group_arbiter #(
    parameter int GROUP_SIZE = 4,
    localparam int LW = $clog2(GROUP_SIZE)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [GROUP_SIZE-1:0] elig,
    input  logic                  take,
    output logic                  any,
    output logic [LW-1:0]         pick
);
    import cags_pkg::*;

    logic [LW-1:0] ptr;

    // Search from the pointer, wrapping, for the first eligible local warp.
    always_comb begin
        logic found;
        found = 1'b0;
        pick  = '0;
        for (int k = 0; k < GROUP_SIZE; k++) begin
            int unsigned j;
            j = (int'(ptr) + k) % GROUP_SIZE;
            if (!found && elig[j]) begin
                pick  = LW'(j);
                found = 1'b1;
            end
        end
    end

    // The group has at least one eligible warp.
    always_comb any = |elig;

    // Advance the pointer past the granted warp; hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr <= '0;
        else if (take && any)
            ptr <= LW'(wrap_next(int'(pick), GROUP_SIZE));
    end

endmodule

// File: rtl/cags_group_select.sv
// Chooses the group that issues this cycle.
// The priority group wins when it has an eligible warp; otherwise the
// lowest-numbered group with an eligible warp is chosen. Purely combinational.
module cags_group_select #(
    parameter int NUM_GROUPS = 4,
    localparam int GW = $clog2(NUM_GROUPS)
) (
    input  logic [NUM_GROUPS-1:0] grp_any,
    input  logic [GW-1:0]         prio,
    output logic                  sel_valid,
    output logic [GW-1:0]         sel_group,
    output logic                  low_valid,
    output logic [GW-1:0]         low_group
);
    // Fixed-order search for the lowest group with an eligible warp.
    always_comb begin
        low_valid = 1'b0;
        low_group = '0;
        for (int g = NUM_GROUPS - 1; g >= 0; g--) begin
            if (grp_any[g]) begin
                low_valid = 1'b1;
                low_group = GW'(g);
            end
        end
    end

    // Priority group first, fixed order as the fallback.
    always_comb begin
        sel_valid = low_valid;
        sel_group = grp_any[prio] ? prio : low_group;
    end

endmodule

// File: rtl/cags_prio_tracker.sv
// Holds the priority group register.
// A data return overrides a switch; a switch needs a group that can issue.
module cags_prio_tracker #(
    parameter int NUM_GROUPS = 4,
    localparam int GW = $clog2(NUM_GROUPS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ret_valid,
    input  logic [GW-1:0] ret_group,
    input  logic          prio_blocked,
    input  logic          low_valid,
    input  logic [GW-1:0] low_group,
    output logic [GW-1:0] prio
);
    logic [GW-1:0] prio_nxt;

    // Next priority: data return, then switch on a blocked group, else hold.
    always_comb begin
        prio_nxt = prio;
        if (ret_valid)
            prio_nxt = ret_group;
        else if (prio_blocked && low_valid)
            prio_nxt = low_group;
    end

    // Priority register, group 0 after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            prio <= '0;
        else
            prio <= prio_nxt;
    end

endmodule

// File: rtl/cags_sched.sv
// Cache-aware grouped warp scheduler, top level.
// Warps are split into groups of consecutive warps. The priority group
// issues first, other groups issue in fixed index order, and each group
// picks round-robin internally.
// Assumes NUM_WARPS and GROUP_SIZE are powers of two, GROUP_SIZE >= 2 and
// at least two groups.
module cags_sched #(
    parameter int NUM_WARPS  = 16,
    parameter int GROUP_SIZE = 4,
    localparam int NG = NUM_WARPS / GROUP_SIZE,
    localparam int WW = $clog2(NUM_WARPS),
    localparam int GW = $clog2(NG),
    localparam int LW = $clog2(GROUP_SIZE)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_WARPS-1:0] warp_ready,
    input  logic [NUM_WARPS-1:0] warp_mem_stall,
    input  logic [NUM_WARPS-1:0] warp_finished,
    input  logic                 dret_valid,
    input  logic [WW-1:0]        dret_warp,
    output logic                 grant_valid,
    output logic [WW-1:0]        grant_warp,
    output logic [GW-1:0]        prio_group
);
    logic [NUM_WARPS-1:0] elig;
    logic [NG-1:0]        grp_any;
    logic [NG-1:0]        grp_blocked;
    logic [LW-1:0]        grp_pick [NG];
    logic                 sel_valid;
    logic [GW-1:0]        sel_group;
    logic                 low_valid;
    logic [GW-1:0]        low_group;

    // A warp may issue only when ready and neither stalled nor finished.
    always_comb elig = warp_ready & ~warp_mem_stall & ~warp_finished;

    // One arbiter per group, plus its blocked flag.
    for (genvar g = 0; g < NG; g++) begin : g_grp
        cags_group_arbiter #(.GROUP_SIZE(GROUP_SIZE)) u_arb (
            .clk   (clk),
            .rst_n (rst_n),
            .elig  (elig[g*GROUP_SIZE +: GROUP_SIZE]),
            .take  (sel_valid && (sel_group == GW'(g))),
            .any   (grp_any[g]),
            .pick  (grp_pick[g])
        );

        // Group blocked when every warp waits on memory or is finished.
        always_comb grp_blocked[g] = &(warp_mem_stall[g*GROUP_SIZE +: GROUP_SIZE]
                                     | warp_finished[g*GROUP_SIZE +: GROUP_SIZE]);
    end

    cags_group_select #(.NUM_GROUPS(NG)) u_sel (
        .grp_any   (grp_any),
        .prio      (prio_group),
        .sel_valid (sel_valid),
        .sel_group (sel_group),
        .low_valid (low_valid),
        .low_group (low_group)
    );

    cags_prio_tracker #(.NUM_GROUPS(NG)) u_prio (
        .clk          (clk),
        .rst_n        (rst_n),
        .ret_valid    (dret_valid),
        .ret_group    (dret_warp[WW-1:LW]),
        .prio_blocked (grp_blocked[prio_group]),
        .low_valid    (low_valid),
        .low_group    (low_group),
        .prio         (prio_group)
    );

    // Compose the granted warp number from the group and local index.
    always_comb begin
        grant_valid = sel_valid;
        grant_warp  = {sel_group, grp_pick[sel_group]};
    end

endmodule

// File: rtl/cags_sched_chk.sv
// Assertion checker for cags_sched, attached with bind.
// Works only from the top module's ports.
module cags_sched_chk #(
    parameter int NUM_WARPS  = 16,
    parameter int GROUP_SIZE = 4,
    localparam int NG = NUM_WARPS / GROUP_SIZE,
    localparam int WW = $clog2(NUM_WARPS),
    localparam int GW = $clog2(NG),
    localparam int LW = $clog2(GROUP_SIZE)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_WARPS-1:0] warp_ready,
    input logic [NUM_WARPS-1:0] warp_mem_stall,
    input logic [NUM_WARPS-1:0] warp_finished,
    input logic                 dret_valid,
    input logic [WW-1:0]        dret_warp,
    input logic                 grant_valid,
    input logic [WW-1:0]        grant_warp,
    input logic [GW-1:0]        prio_group
);
    logic [NUM_WARPS-1:0] ok;
    logic                 prio_has;
    logic                 prio_stuck;
    logic                 first_valid;
    logic [GW-1:0]        first_group;

    // Port-level view of eligibility, priority state and the lowest ready group.
    always_comb begin
        ok          = warp_ready & ~warp_mem_stall & ~warp_finished;
        prio_has    = 1'b0;
        prio_stuck  = 1'b1;
        first_valid = 1'b0;
        first_group = '0;
        for (int w = 0; w < NUM_WARPS; w++) begin
            if (GW'(w / GROUP_SIZE) == prio_group) begin
                prio_has   = prio_has | ok[w];
                prio_stuck = prio_stuck & (warp_mem_stall[w] | warp_finished[w]);
            end
        end
        for (int g = NG - 1; g >= 0; g--)
            if (|ok[g*GROUP_SIZE +: GROUP_SIZE]) begin
                first_valid = 1'b1;
                first_group = GW'(g);
            end
    end

    AST_GRANT_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> ok[grant_warp]); // R2
    AST_PRIO_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        prio_has |-> (grant_valid && grant_warp[WW-1:LW] == prio_group)); // R3
    AST_FALLBACK_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        (!prio_has && first_valid) |-> (grant_valid && grant_warp[WW-1:LW] == first_group)); // R5
    AST_IDLE_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        !first_valid |-> !grant_valid); // R8
    AST_RETURN_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        dret_valid |=> prio_group == $past(dret_warp[WW-1:LW])); // R7
    AST_SWITCH_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        (!dret_valid && prio_stuck && first_valid) |=> prio_group == $past(first_group)); // R6
    AST_PRIO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!dret_valid && !(prio_stuck && first_valid)) |=> $stable(prio_group)); // R5

endmodule

bind cags_sched cags_sched_chk #(.NUM_WARPS(NUM_WARPS), .GROUP_SIZE(GROUP_SIZE)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .warp_ready     (warp_ready),
    .warp_mem_stall (warp_mem_stall),
    .warp_finished  (warp_finished),
    .dret_valid     (dret_valid),
    .dret_warp      (dret_warp),
    .grant_valid    (grant_valid),
    .grant_warp     (grant_warp),
    .prio_group     (prio_group)
);

// File: tb/sim_cags_sched.sv
// Directed bench for cags_sched: one task per scenario, 16 warps in 4 groups.
module sim_cags_sched;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] ready = '0;
    logic [15:0] stall = '0;
    logic [15:0] fin = '0;
    logic        rv = 1'b0;
    logic [3:0]  rw = '0;
    logic        gv;
    logic [3:0]  gw;
    logic [1:0]  pg;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    cags_sched #(.NUM_WARPS(16), .GROUP_SIZE(4)) u0 (
        .clk(clk), .rst_n(rst_n), .warp_ready(ready), .warp_mem_stall(stall),
        .warp_finished(fin), .dret_valid(rv), .dret_warp(rw),
        .grant_valid(gv), .grant_warp(gw), .prio_group(pg)
    );

    always #10 clk = ~clk;

    // Compare one value and report a mismatch.
    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Advance one clock edge; return just after the following falling edge.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Clear inputs and reset for two edges.
    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; ready = '0; stall = '0; fin = '0; rv = 1'b0; rw = '0;
        step(); step();
        rst_n = 1'b1;
        #1;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 prio after reset", pg, 0);
        chk("R8 no grant when idle", gv, 0);
    endtask

    task automatic t_priority();
        do_reset();
        ready = 16'h0202; #1;                 // warps 1 and 9
        chk("R3 prio group wins valid", gv, 1);
        chk("R3 prio group wins warp", gw, 1);
        chk("R9 same-cycle grant", gv, 1);
        step();
        ready = 16'h4200; #1;                 // warps 9 and 14, group 0 empty
        chk("R5 fallback lowest group", gw, 9);
        step();
        chk("R5 prio unchanged", pg, 0);
    endtask

    task automatic t_rr();
        do_reset();
        ready = 16'h000F; #1;
        chk("R1 R4 first local warp", gw, 0); step();
        chk("R4 rr 1", gw, 1); step();
        chk("R4 rr 2", gw, 2); step();
        chk("R4 rr 3", gw, 3); step();
        chk("R4 rr wrap", gw, 0);
        step();
        ready = 16'h0000; fin = 16'h000F; ready[7:4] = 4'hF; #1;
        chk("R4 independent pointer", gw, 4);
    endtask

    task automatic t_skip();
        do_reset();
        ready = 16'h000A; #1;                 // warps 1 and 3
        chk("R4 skip to 1", gw, 1); step();
        chk("R4 skip to 3", gw, 3); step();
        chk("R4 skip wrap to 1", gw, 1);
    endtask

    task automatic t_mask();
        do_reset();
        ready = 16'h0007; stall = 16'h0001; fin = 16'h0002; #1;
        chk("R2 stalled and finished skipped", gw, 2);
        ready = 16'h0001; #1;
        chk("R2 stalled ready not granted", gv, 0);
    endtask

    task automatic t_switch();
        do_reset();
        stall = 16'h000F; step();             // blocked, nothing eligible
        chk("R6 hold with no ready group", pg, 0);
        stall = 16'h0003; fin = 16'h000C; ready = 16'h2401; #1; // warps 10,13 (0 stalled)
        chk("R5 fallback before switch", gw, 10);
        step();
        chk("R6 switch to lowest ready group", pg, 2);
    endtask

    task automatic t_return();
        do_reset();
        ready = 16'h0011; rv = 1'b1; rw = 4'd6; #1;
        chk("R3 grant before return lands", gw, 0);
        step();
        rv = 1'b0; #1;
        chk("R7 return raises group", pg, 1);
        chk("R7 group granted after return", gw, 4);
        ready = 16'h0210; stall = 16'h00F0; rv = 1'b1; rw = 4'd13; // switch would pick 2
        step();
        chk("R7 return beats switch", pg, 3);
        rv = 1'b0;
    endtask

    task automatic t_idle();
        do_reset();
        ready = 16'h000F; step(); step();     // grants 0 and 1
        ready = '0;
        for (int i = 0; i < 3; i++) begin
            #1; chk("R8 idle no grant", gv, 0);
            step();
        end
        chk("R8 prio held when idle", pg, 0);
        rv = 1'b1; rw = 4'd8; step(); rv = 1'b0;
        chk("R8 R7 return during idle", pg, 2);
        ready = 16'h000F; #1;
        chk("R8 pointer held", gw, 2);
    endtask

    // Watchdog: a hung run ends as a failure.
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                errors++;
                $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        t_reset();
        t_priority();
        t_rr();
        t_skip();
        t_mask();
        t_switch();
        t_return();
        t_idle();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule